// File: doc/BRIEF.md
# Two-Channel Split-Zone Address Mapper

This block turns a flat physical byte address into a DRAM channel number and an address local to that channel. It serves a memory system with two channels whose populated sizes may differ. The low part of the address space is striped across both channels one 64-byte cache line at a time, so neighbouring lines land on opposite channels. Whatever the larger channel holds beyond the smaller one's size is placed above that striped region and is reached linearly, on that channel alone.

Both capacities are given in 64-byte lines. The two channels are called logical A and logical B, and A is expected to be the larger or equal one. A swap input decides whether logical A drives physical channel 0 or physical channel 1. A request is presented with a valid strobe. One clock later the block returns the physical channel, the channel-local byte address, a flag telling whether the line came from the striped region, and a flag for an address that lies beyond the installed memory. A configuration in which B is larger than A is reported on its own output. In that case the block ignores B's capacity and maps everything onto A.

Top module: `amap_top`

## Requirements
- R1: Bits [5:0] of the request address, the offset within the line, appear unchanged in bits [5:0] of `map_addr`.
- R2: Let the line index be the request address shifted right by 6. If it is below twice B's effective capacity, line bit 0 picks the logical channel (0 = A, 1 = B), the local line index is the line index shifted right by one, and `map_striped` is 1.
- R3: If the line index is at least twice B's effective capacity but below A plus B's effective capacity, the line goes to logical A, the local line index is the line index minus B's effective capacity, and `map_striped` is 0.
- R4: When both capacities are equal, every in-range address maps into the striped region.
- R5: When B's capacity is zero, every in-range address goes to logical A and the local address equals the request address.
- R6: A line index at or above A's capacity plus B's effective capacity sets `map_oor` to 1 and keeps `map_valid` at 0.
- R7: Physical channel = logical channel XOR `cfg_swap`, so logical A is physical 0 when `cfg_swap` is 0 and physical 1 when it is 1.
- R8: When `cap_b` is greater than `cap_a`, `cfg_bad` is 1 one cycle later and B's effective capacity is taken as zero. Otherwise B's effective capacity is `cap_b`.
- R9: Every output reflects the inputs of the previous clock edge. A cycle with no request gives `map_valid`, `map_oor`, `map_chan`, `map_addr` and `map_striped` all 0 in the following cycle.
- R10: While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Flat physical byte address |
| cap_a | input | ADDR_W-6 | Logical channel A capacity in 64-byte lines |
| cap_b | input | ADDR_W-6 | Logical channel B capacity in 64-byte lines |
| cfg_swap | input | 1 | Binds logical A to physical channel 1 when set |
| map_valid | output | 1 | Mapped result present |
| map_chan | output | 1 | Physical channel number |
| map_addr | output | ADDR_W | Channel-local byte address |
| map_striped | output | 1 | Line was taken from the striped region |
| map_oor | output | 1 | Request lay beyond installed memory |
| cfg_bad | output | 1 | B capacity exceeds A capacity |

## Verification
A wrong zone boundary, a wrong effective capacity or a wrong subtraction shows up at the ports on the very next cycle. It appears as a channel number, a local address or a striped flag that disagrees with a behavioural model evaluated on that request. The bench therefore probes the lines on either side of twice the smaller capacity and on either side of the sum of the two capacities. It does this under several configurations: unequal sizes, equal sizes, B empty, B oversized, and both swap settings. Because the outputs are registered, any latching error also shows within one cycle, for example a result leaking into an idle cycle.

// File: rtl/amap_pkg.sv
package amap_pkg;
    localparam int LINE_OFS_W = 6;

    typedef enum logic {
        LCH_A = 1'b0,
        LCH_B = 1'b1
    } lch_e;
endpackage

// File: rtl/amap_zone_decode.sv
module amap_zone_decode
    import amap_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] cap_a,
    input  logic [LINE_W-1:0] cap_b,
    output logic [LINE_W-1:0] small_cap,
    output logic              in_range,
    output logic              striped,
    output lch_e              lch,
    output logic              bad_cfg
);
    logic [LINE_W:0] total;
    logic [LINE_W:0] twice_small;

    always_comb begin
        bad_cfg     = (cap_b > cap_a);
        small_cap   = bad_cfg ? '0 : cap_b;
        total       = {1'b0, cap_a} + {1'b0, small_cap};
        twice_small = {small_cap, 1'b0};
        in_range    = ({1'b0, line} < total);
        striped     = ({1'b0, line} < twice_small);
        lch         = striped ? lch_e'(line[0]) : LCH_A;
    end
endmodule

// File: rtl/amap_line_xlate.sv
module amap_line_xlate #(
    parameter int LINE_W = 26
) (
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] small_cap,
    input  logic              striped,
    output logic [LINE_W-1:0] local_line
);
    always_comb begin
        if (striped) local_line = line >> 1;
        else         local_line = line - small_cap;
    end
endmodule

// File: rtl/amap_top.sv
module amap_top
    import amap_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit SWAP_EN = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [ADDR_W-LINE_OFS_W-1:0] cap_a,
    input  logic [ADDR_W-LINE_OFS_W-1:0] cap_b,
    input  logic                         cfg_swap,
    output logic                         map_valid,
    output logic                         map_chan,
    output logic [ADDR_W-1:0]            map_addr,
    output logic                         map_striped,
    output logic                         map_oor,
    output logic                         cfg_bad
);
    localparam int LINE_W = ADDR_W - LINE_OFS_W;

    typedef struct packed {
        logic              valid;
        logic              chan;
        logic [ADDR_W-1:0] addr;
        logic              striped;
        logic              oor;
        logic              bad;
    } map_state_t;

    map_state_t st_d, st_q;

    logic [LINE_W-1:0] line;
    logic [LINE_W-1:0] small_cap;
    logic [LINE_W-1:0] local_line;
    logic              in_range;
    logic              striped;
    logic              bad_cfg;
    logic              swap_eff;
    lch_e              lch;

    assign line = req_addr[ADDR_W-1:LINE_OFS_W];

    amap_zone_decode #(.LINE_W(LINE_W)) u_zone (
        .line      (line),
        .cap_a     (cap_a),
        .cap_b     (cap_b),
        .small_cap (small_cap),
        .in_range  (in_range),
        .striped   (striped),
        .lch       (lch),
        .bad_cfg   (bad_cfg)
    );

    amap_line_xlate #(.LINE_W(LINE_W)) u_xlate (
        .line       (line),
        .small_cap  (small_cap),
        .striped    (striped),
        .local_line (local_line)
    );

    generate
        if (SWAP_EN) begin : g_swap
            assign swap_eff = cfg_swap;
        end else begin : g_noswap
            assign swap_eff = 1'b0;
        end
    endgenerate

    always_comb begin
        logic hit;
        hit        = req_valid && in_range;
        st_d       = '0;
        st_d.bad   = bad_cfg;
        st_d.oor   = req_valid && !in_range;
        st_d.valid = hit;
        if (hit) begin
            st_d.chan    = logic'(lch) ^ swap_eff;
            st_d.addr    = {local_line, req_addr[LINE_OFS_W-1:0]};
            st_d.striped = striped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_valid   = st_q.valid;
    assign map_chan    = st_q.chan;
    assign map_addr    = st_q.addr;
    assign map_striped = st_q.striped;
    assign map_oor     = st_q.oor;
    assign cfg_bad     = st_q.bad;

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |-> map_addr[LINE_OFS_W-1:0] == $past(req_addr[LINE_OFS_W-1:0]));

    assert_linear_on_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && !map_striped) |-> map_chan == (SWAP_EN ? $past(cfg_swap) : 1'b0));

    assert_oor_not_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(map_valid && map_oor));

    assert_result_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid || map_oor) |-> $past(req_valid));

    assert_local_within_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && !map_striped) |-> map_addr[ADDR_W-1:LINE_OFS_W] < $past(cap_a));
endmodule

// File: tb/amap_top_bench.sv
`timescale 1ns/1ps
module amap_top_bench;
    localparam int ADDR_W = 32;
    localparam int LW     = ADDR_W - 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LW-1:0]     cap_a = '0;
    logic [LW-1:0]     cap_b = '0;
    logic              cfg_swap = 1'b0;
    logic              map_valid, map_chan, map_striped, map_oor, cfg_bad;
    logic [ADDR_W-1:0] map_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // expectation for the next sample
    bit      e_valid = 0, e_chan = 0, e_str = 0, e_oor = 0, e_bad = 0;
    longint  e_addr = 0;
    string   e_tag = "R9";
    bit      e_swap = 0;

    always #4 clk = ~clk;

    amap_top u_amap_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cap_a(cap_a), .cap_b(cap_b), .cfg_swap(cfg_swap),
        .map_valid(map_valid), .map_chan(map_chan), .map_addr(map_addr),
        .map_striped(map_striped), .map_oor(map_oor), .cfg_bad(cfg_bad)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(e_tag, "valid", map_valid, e_valid);
        chk(e_valid ? e_tag : "R6", "oor", map_oor, e_oor);
        chk("R8", "cfg_bad", cfg_bad, e_bad);
        chk(e_swap ? "R7" : e_tag, "chan", map_chan, e_chan);
        chk(e_tag, "addr", map_addr, e_addr);
        chk("R1", "offset", map_addr[5:0], e_addr % 64);
        chk(e_tag, "striped", map_striped, e_str);
    endtask

    task automatic model(input bit v, input longint addr);
        longint line, a, b, loc;
        bit     lc;
        line = addr / 64; a = cap_a; b = cap_b;
        e_bad = (b > a);
        if (e_bad) b = 0;
        e_swap = cfg_swap;
        e_valid = 0; e_oor = 0; e_chan = 0; e_addr = 0; e_str = 0;
        if (!v) begin e_tag = "R9"; return; end
        if (line >= a + b) begin e_oor = 1; e_tag = "R6"; return; end
        if (line < 2 * b) begin lc = line[0]; loc = line / 2; e_str = 1; end
        else begin lc = 0; loc = line - b; end
        e_valid = 1;
        e_chan  = lc ^ cfg_swap;
        e_addr  = loc * 64 + addr % 64;
        if (e_bad)       e_tag = "R8";
        else if (b == 0) e_tag = "R5";
        else if (a == b) e_tag = "R4";
        else if (e_str)  e_tag = "R2";
        else             e_tag = "R3";
    endtask

    task automatic step(input bit v, input longint addr);
        @(negedge clk);
        compare();
        req_valid = v;
        req_addr  = ADDR_W'(addr);
        model(v, addr);
    endtask

    task automatic set_cfg(input int a, input int b, input bit sw);
        step(0, 0);
        step(0, 0);
        cap_a = LW'(a); cap_b = LW'(b); cfg_swap = sw;
        model(0, 0);
        step(0, 0);
    endtask

    task automatic sweep(input int a, input int b, input bit sw);
        int lim;
        set_cfg(a, b, sw);
        lim = a + (b > a ? 0 : b) + 3;
        for (int l = 0; l < lim; l++) step(1, l * 64 + ((l * 13) % 64));
        for (int k = 0; k < 40; k++) step(($urandom % 4) != 0, $urandom % ((lim + 4) * 64));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "reset valid", map_valid, 0);
        chk("R10", "reset oor", map_oor, 0);
        chk("R10", "reset addr", map_addr, 0);
        chk("R10", "reset chan", map_chan, 0);
        chk("R10", "reset striped", map_striped, 0);
        chk("R10", "reset bad", cfg_bad, 0);
        rst_n = 1'b1;
        model(0, 0);
        sweep(40, 16, 0);
        sweep(40, 16, 1);
        sweep(32, 32, 0);
        sweep(50, 0, 1);
        sweep(10, 20, 0);
        sweep(9, 5, 1);
        // boundaries of 40/16: lines 31, 32, 55, 56
        set_cfg(40, 16, 0);
        step(1, 31 * 64 + 63); step(1, 32 * 64); step(1, 55 * 64 + 1); step(1, 56 * 64);
        step(0, 0); step(1, 0); step(0, 0);
        step(0, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule